// File: doc/BRIEF.md
# Threshold Monitor and Peak Logger

This block sits beside the sample memory of a four-channel capture engine. Every valid sample set, one value per channel, is compared against an upper and a lower limit that software programs for each channel. The first time a channel's sample reaches one of its limits after the capture is armed, the block records the memory write address of that sample and raises a sticky flag. A flag marks that the recorded address is valid.

In parallel, the block keeps a running signed maximum for every channel. A two-bit channel select picks one channel. The block then reports whether that channel's latest sample lies strictly above its lower limit, and the acquisition logic uses this level to gate voltage-triggered capture. Arming a new capture clears all flags, addresses and peaks. Register decoding and the converters themselves live elsewhere.

Top module: `thr_peak_watch`

## Requirements
- R1: After reset, all hit flags and logged addresses are zero, every peak reads -32768 (16'h8000), and `above_lo` is 0.
- R2: A valid sample whose signed value is greater than or equal to that channel's upper limit sets the channel's `hit_hi` bit on the next clock. The same clock loads that channel's `addr_hi` field with `wr_addr`.
- R3: A valid sample whose signed value is less than or equal to that channel's lower limit sets the channel's `hit_lo` bit on the next clock. The same clock loads that channel's `addr_lo` field with `wr_addr`.
- R4: Once a hit flag is set, later crossings of the same limit leave the flag at 1 and leave the logged address unchanged until the next arm.
- R5: Each channel's `peak` field holds the largest signed sample seen on that channel since the last arm. All four channels are tracked.
- R6: `arm` high at a clock edge clears all flags and addresses to 0, resets every peak to 16'h8000 and clears `above_lo`. A sample that is valid in the same cycle is ignored.
- R7: When `smp_vld` is low, no output changes, whatever the sample, address or limit inputs hold.
- R8: On each valid sample, `above_lo` takes the value 1 when the sample of the channel picked by `vt_sel` is strictly greater than that channel's lower limit, and 0 otherwise. Equality gives 0.
- R9: All comparisons are two's-complement signed. A sample of 16'h8001 does not reach an upper limit of 16'h7000.
- R10: A sample exactly equal to a limit counts as reaching it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start of a new capture; clears logged state |
| smp_vld | input | 1 | Sample set valid strobe |
| smp_data | input | 64 | Four 16-bit signed samples, channel c at bits [16c+15:16c] |
| wr_addr | input | 18 | Current sample-memory write address |
| thr_hi | input | 64 | Upper limits, channel c at bits [16c+15:16c] |
| thr_lo | input | 64 | Lower limits, channel c at bits [16c+15:16c] |
| vt_sel | input | 2 | Channel used for the above-lower level |
| hit_hi | output | 4 | Sticky upper-limit hit flags, bit c per channel |
| hit_lo | output | 4 | Sticky lower-limit hit flags, bit c per channel |
| addr_hi | output | 72 | Logged upper-hit addresses, channel c at bits [18c+17:18c] |
| addr_lo | output | 72 | Logged lower-hit addresses, channel c at bits [18c+17:18c] |
| peak | output | 64 | Per-channel signed maximum, channel c at bits [16c+15:16c] |
| above_lo | output | 1 | Selected channel's last valid sample is above its lower limit |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit samples and 18-bit addresses. At these values every channel lane and every value of the select can be reached directly. The signed extremes 16'h8000 and 16'h7FFF can be driven, so the sign handling around the peak floor and the limits is exercised at its true boundaries. The address width matches the full memory span, so any logged address up to 18'h3FFFF can be observed unmodified.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int THR_NCH = 4;
  localparam int THR_SW  = 16;
  localparam int THR_AW  = 18;

  typedef struct packed {
    logic hi;
    logic lo;
  } thr_reach_t;
endpackage

// File: rtl/thr_cmp.sv
module thr_cmp #(
  parameter int SW = 16
) (
  input  logic [SW-1:0]      smp,
  input  logic [SW-1:0]      lim_hi,
  input  logic [SW-1:0]      lim_lo,
  input  logic [SW-1:0]      cur_peak,
  output thr_pkg::thr_reach_t reach,
  output logic               beats_peak
);
  always_comb begin
    reach.hi   = $signed(smp) >= $signed(lim_hi);
    reach.lo   = $signed(smp) <= $signed(lim_lo);
    beats_peak = $signed(smp) >  $signed(cur_peak);
  end
endmodule

// File: rtl/thr_chan.sv
module thr_chan #(
  parameter int SW = 16,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          vld,
  input  logic [SW-1:0] smp,
  input  logic [SW-1:0] lim_hi,
  input  logic [SW-1:0] lim_lo,
  input  logic [AW-1:0] wr_addr,
  output logic          hit_hi,
  output logic          hit_lo,
  output logic [AW-1:0] addr_hi,
  output logic [AW-1:0] addr_lo,
  output logic [SW-1:0] peak
);
  localparam logic [SW-1:0] PEAK_FLOOR = {1'b1, {(SW-1){1'b0}}};

  thr_pkg::thr_reach_t reach;
  logic                beats;

  logic          hit_hi_nx, hit_lo_nx;
  logic [AW-1:0] addr_hi_nx, addr_lo_nx;
  logic [SW-1:0] peak_nx;
  logic          upd_en;

  thr_cmp #(.SW(SW)) u_cmp (
    .smp       (smp),
    .lim_hi    (lim_hi),
    .lim_lo    (lim_lo),
    .cur_peak  (peak),
    .reach     (reach),
    .beats_peak(beats)
  );

  assign upd_en = arm | vld;

  always_comb begin
    hit_hi_nx  = hit_hi;
    hit_lo_nx  = hit_lo;
    addr_hi_nx = addr_hi;
    addr_lo_nx = addr_lo;
    peak_nx    = peak;
    if (arm) begin
      hit_hi_nx  = 1'b0;
      hit_lo_nx  = 1'b0;
      addr_hi_nx = '0;
      addr_lo_nx = '0;
      peak_nx    = PEAK_FLOOR;
    end else if (vld) begin
      if (!hit_hi && reach.hi) begin
        hit_hi_nx  = 1'b1;
        addr_hi_nx = wr_addr;
      end
      if (!hit_lo && reach.lo) begin
        hit_lo_nx  = 1'b1;
        addr_lo_nx = wr_addr;
      end
      if (beats) peak_nx = smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_hi  <= 1'b0;
      hit_lo  <= 1'b0;
      addr_hi <= '0;
      addr_lo <= '0;
      peak    <= PEAK_FLOOR;
    end else if (upd_en) begin
      hit_hi  <= hit_hi_nx;
      hit_lo  <= hit_lo_nx;
      addr_hi <= addr_hi_nx;
      addr_lo <= addr_lo_nx;
      peak    <= peak_nx;
    end
  end
endmodule

// File: rtl/vt_gate.sv
module vt_gate #(
  parameter int NCH = 4,
  parameter int SW  = 16,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              vld,
  input  logic [NCH*SW-1:0] smp_bus,
  input  logic [NCH*SW-1:0] lo_bus,
  input  logic [SELW-1:0]   sel,
  output logic              above_lo
);
  logic [SW-1:0] smp_sel, lo_sel;
  logic          above_nx;

  always_comb begin
    smp_sel = '0;
    lo_sel  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sel == SELW'(c)) begin
        smp_sel = smp_bus[c*SW +: SW];
        lo_sel  = lo_bus[c*SW +: SW];
      end
    end
    if (arm) above_nx = 1'b0;
    else     above_nx = $signed(smp_sel) > $signed(lo_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          above_lo <= 1'b0;
    else if (arm | vld)  above_lo <= above_nx;
  end
endmodule

// File: rtl/thr_peak_watch.sv
module thr_peak_watch #(
  parameter int NCH = thr_pkg::THR_NCH,
  parameter int SW  = thr_pkg::THR_SW,
  parameter int AW  = thr_pkg::THR_AW,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              smp_vld,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NCH*SW-1:0] thr_hi,
  input  logic [NCH*SW-1:0] thr_lo,
  input  logic [SELW-1:0]   vt_sel,
  output logic [NCH-1:0]    hit_hi,
  output logic [NCH-1:0]    hit_lo,
  output logic [NCH*AW-1:0] addr_hi,
  output logic [NCH*AW-1:0] addr_lo,
  output logic [NCH*SW-1:0] peak,
  output logic              above_lo
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    thr_chan #(.SW(SW), .AW(AW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .vld    (smp_vld),
      .smp    (smp_data[c*SW +: SW]),
      .lim_hi (thr_hi[c*SW +: SW]),
      .lim_lo (thr_lo[c*SW +: SW]),
      .wr_addr(wr_addr),
      .hit_hi (hit_hi[c]),
      .hit_lo (hit_lo[c]),
      .addr_hi(addr_hi[c*AW +: AW]),
      .addr_lo(addr_lo[c*AW +: AW]),
      .peak   (peak[c*SW +: SW])
    );
  end

  vt_gate #(.NCH(NCH), .SW(SW)) u_vt (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .vld     (smp_vld),
    .smp_bus (smp_data),
    .lo_bus  (thr_lo),
    .sel     (vt_sel),
    .above_lo(above_lo)
  );
endmodule

// File: rtl/thr_peak_watch_chk.sv
module thr_peak_watch_chk #(
  parameter int NCH = 4,
  parameter int SW  = 16,
  parameter int AW  = 18,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              smp_vld,
  input logic [NCH*SW-1:0] smp_data,
  input logic [AW-1:0]     wr_addr,
  input logic [NCH*SW-1:0] thr_hi,
  input logic [NCH*SW-1:0] thr_lo,
  input logic [SELW-1:0]   vt_sel,
  input logic [NCH-1:0]    hit_hi,
  input logic [NCH-1:0]    hit_lo,
  input logic [NCH*AW-1:0] addr_hi,
  input logic [NCH*AW-1:0] addr_lo,
  input logic [NCH*SW-1:0] peak,
  input logic              above_lo
);
  // R6
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (hit_hi == '0) && (hit_lo == '0) && (addr_hi == '0) && (addr_lo == '0) && !above_lo);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !smp_vld) |=> $stable(hit_hi) && $stable(hit_lo) && $stable(addr_hi)
                           && $stable(addr_lo) && $stable(peak) && $stable(above_lo));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((hit_hi & $past(hit_hi)) == $past(hit_hi)) && ((hit_lo & $past(hit_lo)) == $past(hit_lo)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R2
    hi_addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_hi[c]) |-> addr_hi[c*AW +: AW] == $past(wr_addr));
    // R3
    lo_addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit_lo[c]) |-> addr_lo[c*AW +: AW] == $past(wr_addr));
    // R4
    hi_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_hi[c] && $past(hit_hi[c])) |-> $stable(addr_hi[c*AW +: AW]));
    // R5
    peak_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(arm) |-> $signed(peak[c*SW +: SW]) >= $signed($past(peak[c*SW +: SW])));
  end
endmodule

bind thr_peak_watch thr_peak_watch_chk #(.NCH(NCH), .SW(SW), .AW(AW)) i_chk (.*);

// File: tb/test_thr_peak_watch.sv
module test_thr_peak_watch;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int AW  = 18;

  logic              clk;
  logic              rst_n;
  logic              arm;
  logic              smp_vld;
  logic [NCH*SW-1:0] smp_data;
  logic [AW-1:0]     wr_addr;
  logic [NCH*SW-1:0] thr_hi;
  logic [NCH*SW-1:0] thr_lo;
  logic [1:0]        vt_sel;
  logic [NCH-1:0]    hit_hi, hit_lo;
  logic [NCH*AW-1:0] addr_hi, addr_lo;
  logic [NCH*SW-1:0] peak;
  logic              above_lo;

  thr_peak_watch i_thr_peak_watch (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string             tag;
    logic [NCH-1:0]    hh, hl;
    logic [NCH*AW-1:0] ah, al;
    logic [NCH*SW-1:0] pk;
    logic              ab;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  logic [NCH-1:0]    m_hh, m_hl;
  logic [NCH*AW-1:0] m_ah, m_al;
  logic [NCH*SW-1:0] m_pk;
  logic              m_ab;

  task automatic model_clear();
    m_hh = '0; m_hl = '0; m_ah = '0; m_al = '0; m_ab = 1'b0;
    for (int c = 0; c < NCH; c++) m_pk[c*SW +: SW] = 16'h8000;
  endtask

  task automatic step(input logic a, input logic v, input logic [NCH*SW-1:0] s,
                      input logic [AW-1:0] ad, input logic [1:0] sel, input string tag);
    exp_t e;
    @(negedge clk);
    arm = a; smp_vld = v; smp_data = s; wr_addr = ad; vt_sel = sel;
    if (a) model_clear();
    else if (v) begin
      for (int c = 0; c < NCH; c++) begin
        logic signed [SW-1:0] sv, hv, lv, pv;
        sv = s[c*SW +: SW]; hv = thr_hi[c*SW +: SW];
        lv = thr_lo[c*SW +: SW]; pv = m_pk[c*SW +: SW];
        if (!m_hh[c] && sv >= hv) begin m_hh[c] = 1'b1; m_ah[c*AW +: AW] = ad; end
        if (!m_hl[c] && sv <= lv) begin m_hl[c] = 1'b1; m_al[c*AW +: AW] = ad; end
        if (sv > pv) m_pk[c*SW +: SW] = sv;
      end
      m_ab = $signed(s[sel*SW +: SW]) > $signed(thr_lo[sel*SW +: SW]);
    end
    e.tag = tag; e.hh = m_hh; e.hl = m_hl; e.ah = m_ah; e.al = m_al; e.pk = m_pk; e.ab = m_ab;
    @(posedge clk);
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string f, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "hit_hi", 128'(hit_hi), 128'(e.hh));
      cmp(e.tag, "hit_lo", 128'(hit_lo), 128'(e.hl));
      cmp(e.tag, "addr_hi", 128'(addr_hi), 128'(e.ah));
      cmp(e.tag, "addr_lo", 128'(addr_lo), 128'(e.al));
      cmp(e.tag, "peak", 128'(peak), 128'(e.pk));
      cmp(e.tag, "above_lo", 128'(above_lo), 128'(e.ab));
    end
  end

  function automatic logic [NCH*SW-1:0] pack4(input logic [15:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; smp_vld = 1'b0; smp_data = '0; wr_addr = '0; vt_sel = '0;
    thr_hi = pack4(16'd1000, 16'd1000, 16'd1000, 16'h7000);
    thr_lo = pack4(-16'sd1000, -16'sd1000, -16'sd1000, -16'sd1000);
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(0, 0, '0, '0, 2'd0, "R1");
    // R6 arm
    step(1, 0, '0, '0, 2'd0, "R6");
    // R5 peaks on all channels, no crossing
    step(0, 1, pack4(16'd10, -16'sd20, 16'd300, 16'd5), 18'd5, 2'd0, "R5");
    step(0, 1, pack4(-16'sd3, 16'd40, 16'd100, 16'd6), 18'd6, 2'd0, "R5");
    // R2 / R10 equality reaches upper limit
    step(0, 1, pack4(16'd1000, 16'd0, 16'd0, 16'd0), 18'd7, 2'd0, "R2_R10");
    // R3 / R10 equality reaches lower limit
    step(0, 1, pack4(16'd0, -16'sd1000, 16'd0, 16'd0), 18'h3FFFF, 2'd0, "R3_R10");
    // R4 later crossings do not move logged addresses
    step(0, 1, pack4(16'd2000, -16'sd2000, 16'd0, 16'd0), 18'd12, 2'd0, "R4");
    // R7 no valid, extreme inputs ignored
    step(0, 0, pack4(16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF), 18'd99, 2'd2, "R7");
    step(0, 0, pack4(16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF), 18'd99, 2'd2, "R7");
    // R9 signed: 16'h8001 does not reach 16'h7000 but reaches -1000
    step(0, 1, pack4(16'd0, 16'd0, 16'd0, 16'h8001), 18'd20, 2'd3, "R9");
    // R8 above lower limit on selected channel, then equality gives 0
    step(0, 1, pack4(16'd0, -16'sd999, 16'd0, 16'd0), 18'd21, 2'd1, "R8");
    step(0, 1, pack4(16'd0, -16'sd1000, 16'd0, 16'd0), 18'd22, 2'd1, "R8");
    step(0, 1, pack4(16'd0, 16'd0, -16'sd1001, 16'd0), 18'd23, 2'd2, "R8");
    // R6 arm wins over a simultaneous valid sample
    step(1, 1, pack4(16'd5000, -16'sd5000, 16'd5000, 16'd5000), 18'd30, 2'd0, "R6");
    step(0, 1, pack4(16'h8000, 16'h8000, 16'h8000, 16'h8000), 18'd31, 2'd0, "R5");
    step(0, 0, '0, '0, 2'd0, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule